// File: doc/BRIEF.md
# Dual-Bank GPIO Output-Source Multiplexer

This peripheral controls two banks of general-purpose pins behind a small word-addressed register slave. The transmit-side bank occupies the upper half of every pin-wide register and the receive-side bank occupies the lower half. Every pin has its own direction bit. When a pin is an output, a two-bit field for that pin picks what is driven on it: the bit that software wrote, the bit from an automatic transmit/receive switching controller, or a bit from one of two fabric debug buses. The switching controller and the debug generators sit outside this block and reach it as plain input vectors.

The pad side uses three separate vectors: an output level, an output enable and an input level. Output level and enable are registered, so they always change together. Pad inputs pass through two flops before software can read them, and reading the data word returns these live levels rather than the value that software wrote. Writes carry per-byte enables, so software can update one bank without a read-modify-write of the other.

Top module: `gpio_bank_mux`

## Requirements
- R1: After reset every pin is an input (padOe all zero), padOut is zero, the stored software data, both select words and the direction word are zero, and reading offset 0 with padIn at zero returns zero.
- R2: In the data and direction words, the transmit bank is bits 31:16 (pin n at bit 16+n) and the receive bank is bits 15:0 (pin n at bit n). The auto-switch and debug input vectors use the same packing.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. padOe reflects a direction write two rising edges after the edge that accepts the write, and is unchanged after the first of those edges.
- R4: Each bank has its own select word. Pin n uses bits 2n+1:2n. Code 0 drives the stored software bit, 1 the auto-switch input, 2 debug bus 0 and 3 debug bus 1.
- R5: A pin whose direction bit is 0 has padOe low and padOut low, whatever its select code.
- R6: For a pin that is already an output, a change on its selected source input reaches padOut after exactly one rising edge.
- R7: Reading offset 0 returns padIn as it was two rising edges earlier, with banks packed as in R2.
- R8: Each of the four byte enables gates one byte lane of a write. Bytes whose enable is low keep their old value, so one bank's half can be written alone.
- R9: Writes to word offsets 4 and above change nothing, and reads from them return zero.
- R10: The word map is pin data at offset 0, transmit select at 1, receive select at 2 and direction at 3. Offsets 1 to 3 read back the value last stored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busAddr | input | 4 | Word offset |
| busWrData | input | 32 | Write data |
| busByteEn | input | 4 | Byte-lane enables for a write |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| atrIn | input | 32 | Auto transmit/receive bits, transmit bank high |
| dbg0In | input | 32 | Debug bus 0, transmit bank high |
| dbg1In | input | 32 | Debug bus 1, transmit bank high |
| padIn | input | 32 | Pad input levels |
| padOut | output | 32 | Pad output levels |
| padOe | output | 32 | Pad output enables, 1 drives the pad |

## Verification
The properties assume that reset is held across at least one rising edge. They also assume that busAddr and busWrEn are steady around each sampling edge, so a read seen at an edge belongs to that edge's address. The readback-lag property treats padIn as a value sampled at each edge, which holds because the stimulus changes padIn, the debug buses and the auto-switch inputs only on falling edges. The select sweep rotates the per-pin codes so that every pin of both banks takes all four sources. The source patterns differ in every nibble, so a wrong code or a swapped bank shows on padOut.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_ATR  = 2'd1,
    SRC_DBG0 = 2'd2,
    SRC_DBG1 = 2'd3
  } srcSel_t;

  typedef enum logic [1:0] {
    REG_PINS  = 2'd0,
    REG_TXSEL = 2'd1,
    REG_RXSEL = 2'd2,
    REG_DIR   = 2'd3
  } regIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrPins;
    logic    wrTxSel;
    logic    wrRxSel;
    logic    wrDir;
    logic    rdHit;
    regIdx_t rdIdx;
  } ctrlStrobes_t;

  function automatic logic pickSource(input logic [1:0] code, input logic swBit,
                                      input logic atrBit, input logic d0Bit,
                                      input logic d1Bit);
    logic r;
    case (srcSel_t'(code))
      SRC_SW:   r = swBit;
      SRC_ATR:  r = atrBit;
      SRC_DBG0: r = d0Bit;
      default:  r = d1Bit;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);
  localparam int NUM_REGS = 4;

  logic    inMap;
  regIdx_t idx;

  always_comb begin
    inMap = (busAddr < ADDR_W'(NUM_REGS));
    idx   = regIdx_t'(busAddr[1:0]);
    strobes.wrPins  = busWrEn && inMap && (idx == REG_PINS);
    strobes.wrTxSel = busWrEn && inMap && (idx == REG_TXSEL);
    strobes.wrRxSel = busWrEn && inMap && (idx == REG_RXSEL);
    strobes.wrDir   = busWrEn && inMap && (idx == REG_DIR);
    strobes.rdHit   = inMap;
    strobes.rdIdx   = idx;
  end
endmodule

// File: rtl/gpio_mux_datapath.sv
module gpio_mux_datapath
  import gpio_mux_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [2*PINS/8-1:0] byteEn,
  input  logic [2*PINS-1:0]   wrData,
  input  logic [2*PINS-1:0]   atrIn,
  input  logic [2*PINS-1:0]   dbg0In,
  input  logic [2*PINS-1:0]   dbg1In,
  input  logic [2*PINS-1:0]   padIn,
  output logic [2*PINS-1:0]   padOut,
  output logic [2*PINS-1:0]   padOe,
  output logic [2*PINS-1:0]   rdData
);
  localparam int W    = 2 * PINS;
  localparam int BE_W = W / 8;

  logic [W-1:0] laneMask;
  logic [W-1:0] swDataQ, txSelQ, rxSelQ, dirQ;
  logic [W-1:0] srcBits;
  logic [W-1:0] padOutQ, padOeQ;
  logic [W-1:0] sync1Q, sync2Q;

  for (genvar b = 0; b < BE_W; b++) begin : gLane
    assign laneMask[8*b +: 8] = {8{byteEn[b]}};
  end

  function automatic logic [W-1:0] merge(input logic [W-1:0] oldV,
                                         input logic [W-1:0] newV,
                                         input logic [W-1:0] m);
    return (oldV & ~m) | (newV & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      swDataQ <= '0;
      txSelQ  <= '0;
      rxSelQ  <= '0;
      dirQ    <= '0;
    end else begin
      if (strobes.wrPins)  swDataQ <= merge(swDataQ, wrData, laneMask);
      if (strobes.wrTxSel) txSelQ  <= merge(txSelQ, wrData, laneMask);
      if (strobes.wrRxSel) rxSelQ  <= merge(rxSelQ, wrData, laneMask);
      if (strobes.wrDir)   dirQ    <= merge(dirQ, wrData, laneMask);
    end
  end

  // per-pin source choice, transmit bank in the upper half
  for (genvar p = 0; p < PINS; p++) begin : gPin
    assign srcBits[PINS+p] = pickSource(txSelQ[2*p +: 2], swDataQ[PINS+p],
                                        atrIn[PINS+p], dbg0In[PINS+p], dbg1In[PINS+p]);
    assign srcBits[p]      = pickSource(rxSelQ[2*p +: 2], swDataQ[p],
                                        atrIn[p], dbg0In[p], dbg1In[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      padOutQ <= '0;
      padOeQ  <= '0;
      sync1Q  <= '0;
      sync2Q  <= '0;
    end else begin
      padOutQ <= srcBits & dirQ;
      padOeQ  <= dirQ;
      sync1Q  <= padIn;
      sync2Q  <= sync1Q;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdHit) begin
      case (strobes.rdIdx)
        REG_PINS:  rdData = sync2Q;
        REG_TXSEL: rdData = txSelQ;
        REG_RXSEL: rdData = rxSelQ;
        default:   rdData = dirQ;
      endcase
    end
  end

  assign padOut = padOutQ;
  assign padOe  = padOeQ;
endmodule

// File: rtl/gpio_bank_mux.sv
module gpio_bank_mux
  import gpio_mux_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [2*PINS-1:0]   busWrData,
  input  logic [2*PINS/8-1:0] busByteEn,
  output logic [2*PINS-1:0]   busRdData,
  input  logic [2*PINS-1:0]   atrIn,
  input  logic [2*PINS-1:0]   dbg0In,
  input  logic [2*PINS-1:0]   dbg1In,
  input  logic [2*PINS-1:0]   padIn,
  output logic [2*PINS-1:0]   padOut,
  output logic [2*PINS-1:0]   padOe
);
  ctrlStrobes_t strobes;

  gpio_mux_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_mux_datapath #(.PINS(PINS)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .byteEn  (busByteEn),
    .wrData  (busWrData),
    .atrIn   (atrIn),
    .dbg0In  (dbg0In),
    .dbg1In  (dbg1In),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdData  (busRdData)
  );
endmodule

// File: rtl/gpio_bank_mux_chk.sv
module gpio_bank_mux_chk #(
  parameter int PINS   = 16,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [2*PINS-1:0]   busRdData,
  input logic [2*PINS-1:0]   padIn,
  input logic [2*PINS-1:0]   padOut,
  input logic [2*PINS-1:0]   padOe
);
  logic [1:0] upCnt;

  always_ff @(posedge clk) begin
    if (rst) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_UNDRIVEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (padOut & ~padOe) == '0); // R5

  AST_OE_NEEDS_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(busWrEn && busAddr == ADDR_W'(3)) |=> ##1 $stable(padOe)); // R3

  AST_READBACK_LAG: assert property (@(posedge clk) disable iff (rst)
    (upCnt >= 2'd2 && busAddr == '0) |-> busRdData == $past(padIn, 2)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busAddr >= ADDR_W'(4)) |-> busRdData == '0); // R9
endmodule

bind gpio_bank_mux gpio_bank_mux_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe)
);

// File: tb/sim_gpio_bank_mux.sv
module sim_gpio_bank_mux;
  localparam int PINS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busRdData;
  logic [31:0] atrIn = '0, dbg0In = '0, dbg1In = '0, padIn = '0;
  logic [31:0] padOut, padOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  localparam logic [31:0] P_SW  = 32'h3C5A_96E1;
  localparam logic [31:0] P_ATR = 32'h0FF0_A5A5;
  localparam logic [31:0] P_D0  = 32'h1234_C0DE;
  localparam logic [31:0] P_D1  = 32'hF00D_5E1F;

  always #2 clk = ~clk;

  gpio_bank_mux u0 (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busByteEn(busByteEn), .busRdData(busRdData),
    .atrIn(atrIn), .dbg0In(dbg0In), .dbg1In(dbg1In), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0; busByteEn = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = '0;
  endtask

  function automatic logic [31:0] selWord(input int k);
    logic [31:0] v = '0;
    for (int n = 0; n < PINS; n++) v[2*n +: 2] = 2'((n + k) % 4);
    return v;
  endfunction

  function automatic logic [31:0] expectPads(input int k);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      int code = (b >= PINS) ? ((b - PINS + k) % 4) : ((b + k + 1) % 4);
      case (code)
        0: v[b] = P_SW[b];
        1: v[b] = P_ATR[b];
        2: v[b] = P_D0[b];
        default: v[b] = P_D1[b];
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 padOe", padOe, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    busRead(4'd0, rd); check("R1 pins", rd, 32'h0);
    busRead(4'd1, rd); check("R1 txSel", rd, 32'h0);
    busRead(4'd2, rd); check("R1 rxSel", rd, 32'h0);
    busRead(4'd3, rd); check("R1 dir", rd, 32'h0);

    // R3: all outputs, enable lags two edges
    atrIn = P_ATR; dbg0In = P_D0; dbg1In = P_D1;
    busWrite(4'd3, 32'hFFFF_FFFF, 4'hF);
    check("R3 oe after one edge", padOe, 32'h0);
    @(negedge clk);
    check("R3 oe after two edges", padOe, 32'hFFFF_FFFF);
    busWrite(4'd0, P_SW, 4'hF);

    // R4 R2 R10: rotating per-pin codes across both banks
    for (int k = 0; k < 4; k++) begin
      busWrite(4'd1, selWord(k), 4'hF);
      busWrite(4'd2, selWord(k + 1), 4'hF);
      @(negedge clk);
      check("R4 R2 select sweep", padOut, expectPads(k));
      busRead(4'd1, rd); check("R10 txSel readback", rd, selWord(k));
      busRead(4'd2, rd); check("R10 rxSel readback", rd, selWord(k + 1));
    end
    busRead(4'd3, rd); check("R10 dir readback", rd, 32'hFFFF_FFFF);

    // R6: auto-switch source registered one edge
    busWrite(4'd1, 32'h5555_5555, 4'hF);
    busWrite(4'd2, 32'h5555_5555, 4'hF);
    @(negedge clk);
    check("R6 atr settled", padOut, P_ATR);
    atrIn = 32'h9876_ABCD;
    #1;
    check("R6 before edge", padOut, P_ATR);
    @(negedge clk);
    check("R6 after edge", padOut, 32'h9876_ABCD);

    // R7: readback lags two edges
    padIn = 32'hBEEF_0123;
    @(negedge clk);
    busRead(4'd0, rd); check("R7 after one edge", rd, 32'h0);
    @(negedge clk);
    busRead(4'd0, rd); check("R7 after two edges", rd, 32'hBEEF_0123);

    // R8: byte lanes, transmit half only
    busWrite(4'd1, 32'h0, 4'hF);
    busWrite(4'd2, 32'h0, 4'hF);
    busWrite(4'd0, 32'h0, 4'hF);
    busWrite(4'd0, 32'hFFFF_FFFF, 4'b1100);
    @(negedge clk);
    check("R8 data upper lanes", padOut, 32'hFFFF_0000);
    busWrite(4'd3, 32'h0, 4'b0011);
    busRead(4'd3, rd); check("R8 dir lower lanes", rd, 32'hFFFF_0000);
    busWrite(4'd3, 32'h0, 4'b0100);
    busRead(4'd3, rd); check("R8 dir single lane", rd, 32'hFF00_0000);

    // R5: inputs stay undriven whatever the select
    busWrite(4'd1, 32'hAAAA_AAAA, 4'hF);
    busWrite(4'd2, 32'hAAAA_AAAA, 4'hF);
    busWrite(4'd3, 32'h0000_FFFF, 4'hF);
    @(negedge clk);
    check("R5 oe", padOe, 32'h0000_FFFF);
    check("R5 out", padOut, P_D0 & 32'h0000_FFFF);

    // R9: unmapped offsets
    busWrite(4'd5, 32'hFFFF_FFFF, 4'hF);
    busWrite(4'd12, 32'h1234_5678, 4'hF);
    @(negedge clk);
    busRead(4'd5, rd); check("R9 read zero", rd, 32'h0);
    busRead(4'd15, rd); check("R9 read zero high", rd, 32'h0);
    busRead(4'd1, rd); check("R9 txSel kept", rd, 32'hAAAA_AAAA);
    busRead(4'd3, rd); check("R9 dir kept", rd, 32'h0000_FFFF);
    check("R9 pads kept", padOut, P_D0 & 32'h0000_FFFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule